// File: doc/BRIEF.md
# Byte-wide asynchronous SRAM emulator

This block is a clock-sampled, synthesizable stand-in for a byte-wide asynchronous static RAM. It lets a memory controller be run against realistic read access timing. The block samples active-low chip select, write strobe and output gate, a 19-bit address and a byte of write data on every clock. It decodes the four operating modes, stores bytes on writes, and returns read data on a split bus: a data output, a drive enable that stands in for the tri-state control, and a valid flag.

A read only becomes valid once three timers have all run out. One restarts on an address change, one on chip select going active, and one on the output gate going active. Each has its own latency, given in clock cycles. Until then the bus is driven, but it carries a fixed filler byte and the valid flag is low, so a controller that samples too early is caught. The number of words actually implemented is a parameter, so the model stays small in simulation. Address bits at and above that depth are ignored.

Top module: `sram_emulator`

## Requirements
- R1: While `ce_n` is 1 the block is in standby: `dout_en` and `dout_valid` are 0 for every level of `we_n` and `oe_n`, and this is also the state straight after reset.
- R2: With `ce_n`=0 and `we_n`=0 the byte on `din` is stored at the addressed word on the clock edge, and `dout_en` is 0 whatever `oe_n` is.
- R3: With `ce_n`=0, `we_n`=1 and `oe_n`=1 the block is active but `dout_en` is 0.
- R4: With `ce_n`=0, `we_n`=1 and `oe_n`=0, `dout_en` is 1 in the same cycle, and once no timer is pending, `dout` carries the stored byte with `dout_valid`=1.
- R5: A change of the implemented address bits keeps `dout_valid` at 0 for ADDR_LAT sampled cycles, counting the cycle of the change; the read is valid in the next cycle.
- R6: `ce_n` going from 1 to 0 keeps `dout_valid` at 0 for CE_LAT sampled cycles, counting the cycle of the change.
- R7: `oe_n` going from 1 to 0 keeps `dout_valid` at 0 for OE_LAT cycles (shorter than the others by default). When the address or chip select timer is still running, validity waits for the later of the pending timers.
- R8: Whenever `dout_valid` is 0, `dout` carries the filler byte FILL (default 8'hA5).
- R9: Only address bits below log2(DEPTH) (bits 7:0 by default) select a word. A write through one address is read back through any address with the same low bits, and a change confined to the upper bits does not restart the address timer.
- R10: `dout_en` falls in the same cycle that `ce_n` rises, `oe_n` rises or `we_n` falls, and it stays 1 across address changes while a read is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | ADDR_W (19) | Word address |
| din | input | DATA_W (8) | Write data |
| dout | output | DATA_W (8) | Read data, filler byte while not valid |
| dout_en | output | 1 | Bus drive enable (tri-state control) |
| dout_valid | output | 1 | Read data has met every pending access latency |

## Verification
Two timers can be pending in the same cycle: the address timer and the output gate timer. The testbench provokes this twice, each time by moving the address and dropping the output gate a few cycles later. In one run the address timer expires last; in the other the gate is dropped late enough that the gate timer expires last. The scoreboard expects filler data with the valid flag low in every cycle up to the later expiry, and the stored byte in exactly the cycle after it, so a design that honours only the most recent event, or only the earliest one, is reported.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_IDLE    = 2'd2,
    MODE_READ    = 2'd3
  } sram_mode_e;

  // Truth-table decode of the three active-low strobes.
  function automatic sram_mode_e decode_mode(input logic ce_n,
                                             input logic we_n,
                                             input logic oe_n);
    sram_mode_e m;
    if (ce_n)       m = MODE_STANDBY;
    else if (!we_n) m = MODE_WRITE;
    else if (oe_n)  m = MODE_IDLE;
    else            m = MODE_READ;
    return m;
  endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_model_pkg::*;
(
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_en,
  output logic rd_drive
);

  sram_mode_e mode;

  always_comb begin
    mode     = decode_mode(ce_n, we_n, oe_n);
    wr_en    = (mode == MODE_WRITE);
    rd_drive = (mode == MODE_READ);
  end

endmodule

// File: rtl/sram_event_detect.sv
module sram_event_detect #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic [IDX_W-1:0] idx,
  output logic             addr_start,
  output logic             ce_start,
  output logic             oe_start
);

  logic             ce_q, ce_d;
  logic             oe_q, oe_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  // Next state: remember the levels seen this cycle.
  always_comb begin
    ce_d  = ce_n;
    oe_d  = oe_n;
    idx_d = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      oe_q  <= 1'b1;
      idx_q <= '0;
    end else begin
      ce_q  <= ce_d;
      oe_q  <= oe_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    addr_start = (idx != idx_q);
    ce_start   = ce_q && !ce_n;
    oe_start   = oe_q && !oe_n;
  end

endmodule

// File: rtl/sram_access_timer.sv
module sram_access_timer #(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pending
);

  localparam int unsigned CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0] LOAD = (LAT > 0) ? CNT_W'(LAT - 1) : '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = start || (cnt_q != '0);
    if (start) cnt_d = LOAD;
    else       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign pending = start || (cnt_q != '0);

  // Each event reloads the full window (R5, R6, R7).
  assert_timer_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == LOAD));

  // Without a new event the window shrinks by one per cycle (R7).
  assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/sram_emulator.sv
module sram_emulator
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned ADDR_LAT = 6,
  parameter int unsigned CE_LAT   = 5,
  parameter int unsigned OE_LAT   = 2,
  parameter logic [DATA_W-1:0] FILL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dout_valid
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  idx;
  logic              wr_en, rd_drive;
  logic              addr_start, ce_start, oe_start;
  logic              addr_pend, ce_pend, oe_pend;
  logic [DATA_W-1:0] rd_data;

  assign idx = addr[IDX_W-1:0];

  // Upper address bits select nothing in the reduced array.
  if (ADDR_W > IDX_W) begin : g_addr_hi
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:IDX_W];
  end

  sram_mode_decode u_decode (
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .wr_en    (wr_en),
    .rd_drive (rd_drive)
  );

  sram_event_detect #(.IDX_W(IDX_W)) u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .idx        (idx),
    .addr_start (addr_start),
    .ce_start   (ce_start),
    .oe_start   (oe_start)
  );

  sram_access_timer #(.LAT(ADDR_LAT)) u_addr_timer (
    .clk (clk), .rst_n (rst_n), .start (addr_start), .pending (addr_pend)
  );

  sram_access_timer #(.LAT(CE_LAT)) u_ce_timer (
    .clk (clk), .rst_n (rst_n), .start (ce_start), .pending (ce_pend)
  );

  sram_access_timer #(.LAT(OE_LAT)) u_oe_timer (
    .clk (clk), .rst_n (rst_n), .start (oe_start), .pending (oe_pend)
  );

  sram_byte_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (din),
    .rd_idx  (idx),
    .rd_data (rd_data)
  );

  always_comb begin
    dout_en    = rd_drive;
    dout_valid = rd_drive && !(addr_pend || ce_pend || oe_pend);
    dout       = dout_valid ? rd_data : FILL;
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_en && !dout_valid));

  assert_filler_when_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == FILL));

  assert_no_valid_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (!addr_start && !ce_start && !oe_start));

  assert_gate_rise_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> !dout_en);

endmodule

// File: tb/sram_emulator_test.sv
`timescale 1ns/1ps
module sram_emulator_test;

  localparam logic [7:0] FILL = 8'hA5;

  typedef struct {
    string      req;
    logic       en;
    logic       vld;
    logic [7:0] data;
  } exp_t;

  logic        clk, rst_n;
  logic        ce_n, we_n, oe_n;
  logic [18:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en, dout_valid;

  int   checks, failures;
  logic done;
  exp_t q[$];

  sram_emulator uut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
    .addr (addr), .din (din), .dout (dout), .dout_en (dout_en),
    .dout_valid (dout_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Driver: apply one cycle of stimulus and queue what must be seen in it.
  task automatic step(input logic c, input logic w, input logic o,
                      input logic [18:0] a, input logic [7:0] d,
                      input logic en, input logic vld, input logic [7:0] data,
                      input string req);
    exp_t e;
    @(posedge clk);
    #1;
    ce_n = c; we_n = w; oe_n = o; addr = a; din = d;
    e.req = req; e.en = en; e.vld = vld; e.data = data;
    q.push_back(e);
  endtask

  task automatic rd_wait(input logic [18:0] a, input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, a, 8'h00, 1'b1, 1'b0, FILL, req);
  endtask

  // Monitor: compare at the falling edge, away from the sampling edge.
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (dout_en !== e.en || dout_valid !== e.vld || dout !== e.data) begin
        failures++;
        $display("FAIL %s: en/valid/data actual=%b/%b/%h expected=%b/%b/%h",
                 e.req, dout_en, dout_valid, dout, e.en, e.vld, e.data);
      end
    end
  end

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state and standby for every strobe combination
    step(1, 1, 1, 19'h0, 8'h00, 0, 0, FILL, "R1 reset");
    step(1, 0, 0, 19'h0, 8'h00, 0, 0, FILL, "R1 we/oe low");
    step(1, 1, 0, 19'h0, 8'h00, 0, 0, FILL, "R1 oe low");
    step(1, 0, 1, 19'h0, 8'h00, 0, 0, FILL, "R1 we low");

    // R2: writes, bus not driven even with oe low; R9 alias write
    step(0, 0, 1, 19'h00010, 8'h3C, 0, 0, FILL, "R2 write");
    step(0, 0, 1, 19'h00011, 8'hC3, 0, 0, FILL, "R2 write");
    step(0, 0, 0, 19'h00020, 8'h5A, 0, 0, FILL, "R2 write oe low");
    step(0, 0, 1, 19'h7FF05, 8'h77, 0, 0, FILL, "R2 R9 high write");

    // R3: active, outputs off; lets every timer expire
    for (int i = 0; i < 8; i++) step(0, 1, 1, 19'h00010, 8'h00, 0, 0, FILL, "R3 idle");

    // R7/R4: gate-initiated read
    rd_wait(19'h00010, 2, "R7 oe latency");
    step(0, 1, 0, 19'h00010, 8'h00, 1, 1, 8'h3C, "R4 read data");
    step(0, 1, 0, 19'h00010, 8'h00, 1, 1, 8'h3C, "R4 read held");

    // R5/R10: address-initiated read, bus stays driven
    rd_wait(19'h00011, 6, "R5 R10 addr latency");
    step(0, 1, 0, 19'h00011, 8'h00, 1, 1, 8'hC3, "R5 read data");

    // R9: upper bits only, no restart; alias read
    step(0, 1, 0, 19'h00111, 8'h00, 1, 1, 8'hC3, "R9 upper bits ignored");
    rd_wait(19'h00005, 6, "R9 alias latency");
    step(0, 1, 0, 19'h00005, 8'h00, 1, 1, 8'h77, "R9 alias data");

    // R10: drive drops with each strobe
    step(0, 1, 1, 19'h00005, 8'h00, 0, 0, FILL, "R10 oe rise");
    rd_wait(19'h00005, 2, "R7 oe re-assert");
    step(0, 1, 0, 19'h00005, 8'h00, 1, 1, 8'h77, "R7 oe read");
    step(1, 1, 0, 19'h00005, 8'h00, 0, 0, FILL, "R10 ce rise");
    step(0, 0, 0, 19'h00030, 8'h99, 0, 0, FILL, "R10 we fall");

    // R6: chip-select-initiated read
    for (int i = 0; i < 8; i++) step(1, 1, 0, 19'h00020, 8'h00, 0, 0, FILL, "R1 standby");
    rd_wait(19'h00020, 5, "R6 ce latency");
    step(0, 1, 0, 19'h00020, 8'h00, 1, 1, 8'h5A, "R6 read data");

    // R7: address timer outlasts the gate timer
    step(0, 1, 1, 19'h00030, 8'h00, 0, 0, FILL, "R3 addr move");
    rd_wait(19'h00030, 5, "R7 addr dominates");
    step(0, 1, 0, 19'h00030, 8'h00, 1, 1, 8'h99, "R7 addr dominates data");

    // R7: gate timer outlasts the address timer
    step(0, 1, 1, 19'h00010, 8'h00, 0, 0, FILL, "R3 addr move");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 19'h00010, 8'h00, 0, 0, FILL, "R3 idle");
    rd_wait(19'h00010, 2, "R7 oe dominates");
    step(0, 1, 0, 19'h00010, 8'h00, 1, 1, 8'h3C, "R7 oe dominates data");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule